// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

The block collects single-cycle event pulses into a set of leaf register groups and folds them into one master summary word. Each leaf group holds a raw-level view, a mask, a latched pending word and an enable word. An arriving event is latched only when its mask bit is clear. The AND of pending and enable is the group's contribution. A fixed slice table routes each contribution onto master summary bits. A group may drive two master bits, one per 16-bit half, or one master bit for all 32 bits.

Software reaches every register through a simple valid/write strobe port with a registered read result. Only the top bit of the master word can be written, and it acts as the global enable. A small evaluation state machine decides whether to raise the message-interrupt request. It has three states. EV_IDLE waits and moves to EV_CHECK when an evaluation is requested. EV_CHECK moves to EV_FIRE when the global enable, the message-enable input and some summary bit are all 1; otherwise it returns to EV_IDLE. EV_FIRE drives a one-cycle request pulse and returns to EV_IDLE.

Three things request an evaluation: an event pulse, a write to a mask or enable register, and a write to the master word. A request that arrives while an evaluation is in progress is kept and served next.

Top module: `irq_hier_agg`

## Requirements
- R1: After reset, every mask register reads 0xFFFFFFFF, every pending and enable register reads 0, the master word reads 0 and `irq_req` is 0.
- R2: Group g occupies byte addresses g*0x10 to g*0x10+0xC: raw level at +0x0, mask at +0x4, pending at +0x8, enable at +0xC. The master word is at 0x100. A read returns its data on `bus_rdata` one cycle after the strobe, and each register keeps its own written value.
- R3: An event (group `evt_group`, bit `evt_bit`) sets that pending bit only when the matching mask bit is 0. A masked event is dropped, and clearing the mask afterwards does not bring it back.
- R4: Writing the pending register clears exactly the bits written as 1 and leaves the others unchanged.
- R5: When an event and a pending-register write land in the same cycle, the event is applied first. A bit that is both set and cleared in that cycle ends at 0.
- R6: Master bit b is 1 exactly while (pending AND enable AND slice) of its source group is nonzero, and it falls again when that term clears. Bit 0 takes the low 16 bits of group 0 and bit 1 its high 16 bits. Bits 2 and 3 do the same for group 1. Bits 16, 17, 18, 20, 22 and 23 take all 32 bits of groups 2 to 7. All other bits read 0.
- R7: A master write changes only bit 31, the global enable. Summary bits read back as computed, whatever was written.
- R8: `irq_req` is a one-cycle pulse. It is issued in the second cycle after the triggering event or write, when that evaluation finds a nonzero summary.
- R9: No request is issued while the global enable is 0 or while `msg_enable` is 0.
- R10: A write to a mask, enable or master register starts an evaluation, so a pending bit that was already latched raises a request once it is enabled.
- R11: The raw-level register returns the current `src_level` slice of its group, whatever the mask holds.
- R12: A write to a pending register on its own starts no evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_valid | input | 1 | Event pulse |
| evt_group | input | 3 | Leaf group of the event |
| evt_bit | input | 5 | Bit index of the event in its group |
| src_level | input | 256 | Raw event levels, 32 bits per group |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| msg_enable | input | 1 | Message-interrupt enable control |
| irq_req | output | 1 | One-cycle message-interrupt request |

## Verification
The aggregation is driven with pending bits in the low and high halves of a split group. This shows that each half lands only on its own master bit, and that clearing one half drops only that bit. Whole-word groups at both ends of the map are checked against their scattered master bits. The request path is tried in four cases: a latched bit behind a zero enable, a later enable write, a zero global or message enable, and a pending-only write. Together these separate "evaluated and fired" from "evaluated and suppressed" from "never evaluated". Events are also sent against set mask bits, and one event is made to collide with a clear of the same bit. These show that dropped events stay dropped and that the clear wins.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

    // word offsets inside a leaf group (byte offset / 4)
    typedef enum logic [1:0] {
        OFS_LEVEL  = 2'd0,
        OFS_MASK   = 2'd1,
        OFS_PEND   = 2'd2,
        OFS_ENABLE = 2'd3
    } reg_ofs_e;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_CHECK = 2'd1,
        EV_FIRE  = 2'd2
    } ev_state_e;

    // source group of a master summary bit, -1 when unmapped
    function automatic int map_group(input int b);
        case (b)
            0, 1:    return 0;
            2, 3:    return 1;
            16:      return 2;
            17:      return 3;
            18:      return 4;
            20:      return 5;
            22:      return 6;
            23:      return 7;
            30:      return 8;
            default: return -1;
        endcase
    endfunction

    // slice of the source group that feeds a master summary bit
    function automatic logic [31:0] map_slice(input int b);
        case (b)
            0, 2:    return 32'h0000_FFFF;
            1, 3:    return 32'hFFFF_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/irq_leaf_group.sv
`timescale 1ns/1ps
module irq_leaf_group #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_set,
    input  logic             wr_mask,
    input  logic             wr_enable,
    input  logic             wr_pend,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] pend_q,
    output logic [REG_W-1:0] enable_q,
    output logic [REG_W-1:0] contrib
);
    logic [REG_W-1:0] pend_d;

    // event set first, then write-1-to-clear
    always_comb begin
        pend_d = pend_q | (evt_set & ~mask_q);
        if (wr_pend) begin
            pend_d = pend_d & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            pend_q   <= '0;
            enable_q <= '0;
        end else begin
            if (wr_mask) begin
                mask_q <= wdata;
            end
            if (wr_enable) begin
                enable_q <= wdata;
            end
            pend_q <= pend_d;
        end
    end

    assign contrib = pend_q & enable_q;

endmodule

// File: rtl/irq_master_map.sv
`timescale 1ns/1ps
module irq_master_map #(
    parameter int NUM_GROUPS = 8,
    parameter int REG_W      = 32
) (
    input  logic [NUM_GROUPS*REG_W-1:0] contrib_flat,
    output logic [REG_W-2:0]            summary
);
    for (genvar b = 0; b < REG_W - 1; b++) begin : g_bit
        localparam int SRC = irq_agg_pkg::map_group(b);
        if (SRC >= 0 && SRC < NUM_GROUPS) begin : g_on
            localparam logic [REG_W-1:0] SLICE = REG_W'(irq_agg_pkg::map_slice(b));
            assign summary[b] = |(contrib_flat[SRC*REG_W +: REG_W] & SLICE);
        end else begin : g_off
            assign summary[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_eval_fsm.sv
`timescale 1ns/1ps
module irq_eval_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic global_en,
    input  logic msg_en,
    input  logic work_any,
    output logic irq_req
);
    ev_state_e state_q;
    ev_state_e state_d;
    logic      want_q;

    // outstanding evaluation request, kept while busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q <= 1'b0;
        end else begin
            want_q <= trigger | (want_q & (state_q != EV_IDLE));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:  if (want_q) state_d = EV_CHECK;
            EV_CHECK: state_d = (global_en && msg_en && work_any) ? EV_FIRE : EV_IDLE;
            EV_FIRE:  state_d = EV_IDLE;
            default:  state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        irq_req = 1'b0;
        unique case (state_q)
            EV_FIRE: irq_req = 1'b1;
            default: irq_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_hier_agg.sv
`timescale 1ns/1ps
module irq_hier_agg
    import irq_agg_pkg::*;
#(
    parameter int                NUM_GROUPS  = 8,
    parameter int                REG_W       = 32,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] MASTER_ADDR = 12'h100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        evt_valid,
    input  logic [$clog2(NUM_GROUPS)-1:0] evt_group,
    input  logic [$clog2(REG_W)-1:0]    evt_bit,
    input  logic [NUM_GROUPS*REG_W-1:0] src_level,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic                        msg_enable,
    output logic                        irq_req
);
    localparam int                GRP_W    = $clog2(NUM_GROUPS);
    localparam logic [ADDR_W-1:0] GRP_SPAN = ADDR_W'(NUM_GROUPS * 16);

    logic [REG_W-1:0] mask_arr   [NUM_GROUPS];
    logic [REG_W-1:0] pend_arr   [NUM_GROUPS];
    logic [REG_W-1:0] enable_arr [NUM_GROUPS];
    logic [NUM_GROUPS*REG_W-1:0] contrib_flat;
    logic [REG_W-2:0] summary;
    logic             summary_any;
    logic             gen_en;
    logic             is_grp;
    logic             master_hit;
    logic             wr_any;
    logic [GRP_W-1:0] grp_sel;
    reg_ofs_e         ofs;
    logic             trigger;
    logic [REG_W-1:0] rd_val;
    logic [REG_W-1:0] rdata_q;

    // address decode
    assign is_grp     = (bus_addr < GRP_SPAN) && (bus_addr[1:0] == 2'b00);
    assign master_hit = (bus_addr == MASTER_ADDR);
    assign grp_sel    = bus_addr[GRP_W+3:4];
    assign ofs        = reg_ofs_e'(bus_addr[3:2]);
    assign wr_any     = bus_valid && bus_write;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic             sel;
        logic [REG_W-1:0] evt_set;
        assign sel     = wr_any && is_grp && (grp_sel == GRP_W'(g));
        assign evt_set = (evt_valid && (evt_group == GRP_W'(g)))
                       ? (REG_W'(1) << evt_bit) : '0;

        irq_leaf_group #(.REG_W(REG_W)) u_leaf (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_set   (evt_set),
            .wr_mask   (sel && (ofs == OFS_MASK)),
            .wr_enable (sel && (ofs == OFS_ENABLE)),
            .wr_pend   (sel && (ofs == OFS_PEND)),
            .wdata     (bus_wdata),
            .mask_q    (mask_arr[g]),
            .pend_q    (pend_arr[g]),
            .enable_q  (enable_arr[g]),
            .contrib   (contrib_flat[g*REG_W +: REG_W])
        );
    end

    irq_master_map #(.NUM_GROUPS(NUM_GROUPS), .REG_W(REG_W)) u_map (
        .contrib_flat (contrib_flat),
        .summary      (summary)
    );

    assign summary_any = |summary;

    // global enable: the only writable master bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
        end else if (wr_any && master_hit) begin
            gen_en <= bus_wdata[REG_W-1];
        end
    end

    assign trigger = evt_valid
                   || (wr_any && master_hit)
                   || (wr_any && is_grp && ((ofs == OFS_MASK) || (ofs == OFS_ENABLE)));

    irq_eval_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (trigger),
        .global_en (gen_en),
        .msg_en    (msg_enable),
        .work_any  (summary_any),
        .irq_req   (irq_req)
    );

    // read mux
    always_comb begin
        rd_val = '0;
        if (master_hit) begin
            rd_val = {gen_en, summary};
        end else if (is_grp) begin
            unique case (ofs)
                OFS_LEVEL:  rd_val = src_level[grp_sel*REG_W +: REG_W];
                OFS_MASK:   rd_val = mask_arr[grp_sel];
                OFS_PEND:   rd_val = pend_arr[grp_sel];
                OFS_ENABLE: rd_val = enable_arr[grp_sel];
                default:    rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_valid && !bus_write) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_agg_chk.sv
`timescale 1ns/1ps
module irq_agg_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_req,
    input logic gen_en,
    input logic msg_enable,
    input logic summary_any,
    input logic master_wr,
    input logic wdata_msb
);
    // R1: reset holds the request low
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !irq_req);

    // R8: request never lasts longer than one cycle
    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    // R8: a request follows an evaluation that saw pending work
    p_needs_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(summary_any));

    // R9: both enables were on when the request was decided
    p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(gen_en && msg_enable));

    // R7: a master write loads the global enable from the top data bit
    p_master_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        master_wr |=> (gen_en == $past(wdata_msb)));

endmodule

bind irq_hier_agg irq_agg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .gen_en      (gen_en),
    .msg_enable  (msg_enable),
    .summary_any (summary_any),
    .master_wr   (wr_any && master_hit),
    .wdata_msb   (bus_wdata[REG_W-1])
);

// File: tb/sim_irq_hier_agg.sv
`timescale 1ns/1ps
module sim_irq_hier_agg;
    localparam int NG = 8;
    localparam int W  = 32;
    localparam logic [11:0] MASTER = 12'h100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          evt_valid;
    logic [2:0]    evt_group;
    logic [4:0]    evt_bit;
    logic [NG*W-1:0] src_level;
    logic          bus_valid;
    logic          bus_write;
    logic [11:0]   bus_addr;
    logic [W-1:0]  bus_wdata;
    logic [W-1:0]  bus_rdata;
    logic          msg_enable;
    logic          irq_req;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    irq_hier_agg u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_group(evt_group),
        .evt_bit(evt_bit), .src_level(src_level), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .msg_enable(msg_enable), .irq_req(irq_req)
    );

    always @(negedge clk) if (rst_n && irq_req) irq_cnt++;

    function automatic logic [11:0] ra(input int g, input int ofs);
        return 12'(g * 16 + ofs * 4);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt_valid = 0; evt_group = 0; evt_bit = 0; src_level = '0;
        bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0; msg_enable = 0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic fire(input int g, input int b);
        @(negedge clk);
        evt_valid = 1; evt_group = 3'(g); evt_bit = 5'(b);
        @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        do_reset();
        chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
        rd(ra(0, 1), d); chk("R1 mask g0", d, 32'hFFFF_FFFF);
        rd(ra(7, 1), d); chk("R1 mask g7", d, 32'hFFFF_FFFF);
        rd(ra(3, 2), d); chk("R1 pending g3", d, 32'd0);
        rd(ra(5, 3), d); chk("R1 enable g5", d, 32'd0);
        rd(MASTER, d);   chk("R1 master", d, 32'd0);
    endtask

    task automatic t_layout();
        logic [W-1:0] d;
        do_reset();
        wr(ra(3, 1), 32'h1234_5678);
        wr(ra(3, 3), 32'hA5A5_A5A5);
        wr(ra(5, 1), 32'h0F0F_0000);
        rd(ra(3, 1), d); chk("R2 mask g3", d, 32'h1234_5678);
        rd(ra(3, 3), d); chk("R2 enable g3", d, 32'hA5A5_A5A5);
        rd(ra(5, 1), d); chk("R2 mask g5", d, 32'h0F0F_0000);
        rd(ra(4, 1), d); chk("R2 mask g4 untouched", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask();
        logic [W-1:0] d;
        do_reset();
        wr(ra(0, 1), 32'hFFFF_FFFE);
        fire(0, 0);
        rd(ra(0, 2), d); chk("R3 unmasked event latched", d, 32'h1);
        fire(0, 1);
        rd(ra(0, 2), d); chk("R3 masked event dropped", d, 32'h1);
        wr(ra(0, 1), 32'h0);
        rd(ra(0, 2), d); chk("R3 dropped stays dropped", d, 32'h1);
    endtask

    task automatic t_clear();
        logic [W-1:0] d;
        do_reset();
        wr(ra(0, 1), 32'h0);
        fire(0, 0); fire(0, 5); fire(0, 2);
        wr(ra(0, 2), 32'h20);
        rd(ra(0, 2), d); chk("R4 write-1-to-clear", d, 32'h5);
        // same cycle: event bit 7 and clear of bit 7
        @(negedge clk);
        evt_valid = 1; evt_group = 0; evt_bit = 5'd7;
        bus_valid = 1; bus_write = 1; bus_addr = ra(0, 2); bus_wdata = 32'h80;
        @(negedge clk);
        evt_valid = 0; bus_valid = 0; bus_write = 0;
        rd(ra(0, 2), d); chk("R5 clear wins over same-cycle event", d, 32'h5);
    endtask

    task automatic t_map();
        logic [W-1:0] d;
        do_reset();
        for (int g = 0; g < NG; g++) begin
            wr(ra(g, 1), 32'h0);
            wr(ra(g, 3), 32'hFFFF_FFFF);
        end
        fire(0, 3);
        rd(MASTER, d); chk("R6 g0 low half -> bit0", d, 32'h1);
        fire(0, 20);
        rd(MASTER, d); chk("R6 g0 high half -> bit1", d, 32'h3);
        wr(ra(0, 2), 32'h8);
        rd(MASTER, d); chk("R6 bit0 recomputed after clear", d, 32'h2);
        wr(ra(0, 3), 32'h0000_FFFF);
        rd(MASTER, d); chk("R6 enable gates contribution", d, 32'h0);
        fire(1, 17); fire(2, 31); fire(7, 0);
        rd(MASTER, d); chk("R6 g1 high, g2, g7 bits", d, 32'h0081_0008);
    endtask

    task automatic t_master_wr();
        logic [W-1:0] d;
        do_reset();
        wr(MASTER, 32'hFFFF_FFFF);
        rd(MASTER, d); chk("R7 only bit31 writable", d, 32'h8000_0000);
        wr(MASTER, 32'h0);
        rd(MASTER, d); chk("R7 enable cleared", d, 32'h0);
    endtask

    task automatic t_request();
        int base;
        do_reset();
        msg_enable = 1;
        wr(MASTER, 32'h8000_0000);
        wr(ra(2, 1), 32'h0);
        base = irq_cnt;
        fire(2, 9);
        idle(6);
        chk("R10 latched but disabled: no request", 32'(irq_cnt - base), 32'd0);
        base = irq_cnt;
        wr(ra(2, 3), 32'h200);
        idle(6);
        chk("R10 enable write raises request", 32'(irq_cnt - base), 32'd1);
        base = irq_cnt;
        wr(ra(2, 1), 32'h0);
        idle(6);
        chk("R10 mask write re-evaluates", 32'(irq_cnt - base), 32'd1);
        // exact timing of the pulse
        fire(2, 9);
        @(negedge clk); chk("R8 no pulse one cycle after", {31'd0, irq_req}, 32'd0);
        @(negedge clk); chk("R8 pulse two cycles after", {31'd0, irq_req}, 32'd1);
        @(negedge clk); chk("R8 pulse is one cycle", {31'd0, irq_req}, 32'd0);
        idle(3);
        // R12: pending write alone
        fire(2, 3);
        idle(6);
        base = irq_cnt;
        wr(ra(2, 2), 32'h8);
        idle(6);
        chk("R12 pending write starts no evaluation", 32'(irq_cnt - base), 32'd0);
    endtask

    task automatic t_gate();
        int base;
        do_reset();
        msg_enable = 1;
        wr(ra(0, 1), 32'h0);
        wr(ra(0, 3), 32'hFFFF_FFFF);
        base = irq_cnt;
        fire(0, 0);
        idle(6);
        chk("R9 global enable 0 blocks", 32'(irq_cnt - base), 32'd0);
        msg_enable = 0;
        base = irq_cnt;
        wr(MASTER, 32'h8000_0000);
        fire(0, 1);
        idle(6);
        chk("R9 message enable 0 blocks", 32'(irq_cnt - base), 32'd0);
        msg_enable = 1;
        base = irq_cnt;
        fire(0, 2);
        idle(6);
        chk("R9 both enables on fires", 32'(irq_cnt - base), 32'd1);
    endtask

    task automatic t_level();
        logic [W-1:0] d;
        do_reset();
        src_level[4*W +: W] = 32'hDEAD_BEEF;
        rd(ra(4, 0), d); chk("R11 raw level through set mask", d, 32'hDEAD_BEEF);
        rd(ra(3, 0), d); chk("R11 other group level", d, 32'h0);
        wr(ra(4, 1), 32'h0);
        src_level[4*W +: W] = 32'h0000_1234;
        rd(ra(4, 0), d); chk("R11 level follows input", d, 32'h0000_1234);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_layout();
        t_mask();
        t_clear();
        t_map();
        t_master_wr();
        t_request();
        t_gate();
        t_level();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule